// File: doc/BRIEF.md
# Reversible-Gate Ripple Adder/Subtractor

This block adds or subtracts two unsigned operands with a ripple chain built only from reversible primitives. There are two primitives. The two-line controlled-NOT cell passes its first line through and XORs it into the second. The three-line Peres cell passes its first line, forms the XOR of the first two, and XORs their AND into the third. Each primitive has exactly as many outputs as inputs. A single mode bit selects the operation. In subtract mode the chain carries a borrow; the block does not invert the second operand to form a two's complement.

Stage 0 is a half cell: two controlled-NOT cells, one Peres cell and one constant-zero line. Every higher stage is a full cell: two controlled-NOT cells, two Peres cells and one constant-zero line. The mode bit is XORed into operand A before the Peres cell that forms the carry term. A second controlled-NOT cell removes the mode bit again from the result bit. Every output line that leaves a primitive unused is brought out on a garbage port, so reversibility and the wiring can be observed. An optional register stage, which is on by default, holds the result, the final carry/borrow and the garbage lines.

Top module: `rev_addsub`

## Requirements
- R1: The controlled-NOT primitive maps inputs (x, y) to outputs (x, x XOR y).
- R2: The Peres primitive maps inputs (x, y, z) to outputs (x, x XOR y, (x AND y) XOR z).
- R3: Each primitive's input-to-output mapping is one-to-one over all of its input combinations (4 for the two-line cell, 8 for the three-line cell).
- R4: With `sub_i` = 0, `{cb_o, res_o}` equals the 9-bit sum A + B.
- R5: With `sub_i` = 1, `res_o` equals (A − B) mod 256, and `cb_o` is 1 exactly when A < B, as an unsigned comparison.
- R6: A result bit never sees the mode bit directly: bit i equals A[i] XOR B[i] XOR the carry/borrow into stage i, and bit 0 equals A[0] XOR B[0] in both modes.
- R7: Garbage layout. Bit 0 is A[0] XOR mode and bit 1 is the mode bit. For stage i ≥ 1 the base index is k = 2 + 3(i−1): bit k is A[i] XOR mode, bit k+1 is A[i] XOR mode XOR B[i], and bit k+2 is the mode bit. The port is 23 bits wide.
- R8: With the output register enabled, a new input set shows on every output exactly one clock edge after it is applied. Before that edge the previous result is held.
- R9: While `rst_n` is low, `res_o`, `cb_o` and `garb_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | 8 | Operand A (minuend in subtract mode) |
| b_i | input | 8 | Operand B (subtrahend in subtract mode) |
| sub_i | input | 1 | Mode: 0 add, 1 subtract |
| res_o | output | 8 | Sum or difference |
| cb_o | output | 1 | Final carry (add) or borrow (subtract) |
| garb_o | output | 23 | All garbage lines of the primitives, in the layout of R7 |

## Verification
The bench drives operand pairs where the carry or borrow must ripple through all eight stages, such as 0xFF + 0x01 and 0x00 − 0x01. If the mode bit were applied in the wrong place, or the generate term were taken from the plain A, subtraction would give a wrong borrow or would disturb the difference bits, while addition would still look correct. Swapping the wiring of the Peres lines, or skipping the undo cell, shows up as a garbage pattern that differs from R7 or as a bit 0 that follows the mode. A primitive that lost bijectivity is caught by an exhaustive sweep that records every output code. An extra or missing pipeline stage is caught by sampling just before and just after the capture edge.

// File: rtl/rev_addsub_pkg.sv
package rev_addsub_pkg;

  // Two-line controlled-NOT: {p, q} = {x, x ^ y}
  function automatic logic [1:0] cnot_map(input logic x, input logic y);
    return {x, x ^ y};
  endfunction

  // Three-line Peres: {p, q, r} = {x, x ^ y, (x & y) ^ z}
  function automatic logic [2:0] peres_map(input logic x, input logic y, input logic z);
    return {x, x ^ y, (x & y) ^ z};
  endfunction

  // Garbage lines per stage kind
  localparam int unsigned HALF_GARB = 2;
  localparam int unsigned FULL_GARB = 3;

  function automatic int unsigned garb_width(input int unsigned w);
    return HALF_GARB + FULL_GARB * (w - 1);
  endfunction

endpackage

// File: rtl/rev_feynman.sv
module rev_feynman
  import rev_addsub_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  output logic p_o,
  output logic q_o
);
  assign {p_o, q_o} = cnot_map(a_i, b_i);
endmodule

// File: rtl/rev_peres.sv
module rev_peres
  import rev_addsub_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  assign {p_o, q_o, r_o} = peres_map(a_i, b_i, c_i);
endmodule

// File: rtl/rev_half_cell.sv
// Stage 0: mode-skewed A, one Peres with constant zero, undo cell on the result.
module rev_half_cell (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       mode_i,
  output logic       d_o,
  output logic       cout_o,
  output logic [1:0] garb_o
);
  logic mode_fwd, a_skew, a_skew_pass, xor_skew, mode_spent;

  rev_feynman u_skew (.a_i(mode_i), .b_i(a_i), .p_o(mode_fwd), .q_o(a_skew));
  rev_peres   u_gen  (.a_i(a_skew), .b_i(b_i), .c_i(1'b0),
                      .p_o(a_skew_pass), .q_o(xor_skew), .r_o(cout_o));
  rev_feynman u_undo (.a_i(mode_fwd), .b_i(xor_skew), .p_o(mode_spent), .q_o(d_o));

  assign garb_o = {mode_spent, a_skew_pass};
endmodule

// File: rtl/rev_full_cell.sv
// Stage i>0: mode-skewed A, generate Peres, propagate Peres, undo cell.
module rev_full_cell (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       mode_i,
  input  logic       cin_i,
  output logic       d_o,
  output logic       cout_o,
  output logic [2:0] garb_o
);
  logic mode_fwd, a_skew, a_skew_pass, xor_skew, gen_term;
  logic xor_skew_pass, d_skew, mode_spent;

  rev_feynman u_skew (.a_i(mode_i), .b_i(a_i), .p_o(mode_fwd), .q_o(a_skew));
  rev_peres   u_gen  (.a_i(a_skew), .b_i(b_i), .c_i(1'b0),
                      .p_o(a_skew_pass), .q_o(xor_skew), .r_o(gen_term));
  rev_peres   u_prop (.a_i(xor_skew), .b_i(cin_i), .c_i(gen_term),
                      .p_o(xor_skew_pass), .q_o(d_skew), .r_o(cout_o));
  rev_feynman u_undo (.a_i(mode_fwd), .b_i(d_skew), .p_o(mode_spent), .q_o(d_o));

  assign garb_o = {mode_spent, xor_skew_pass, a_skew_pass};
endmodule

// File: rtl/rev_addsub.sv
module rev_addsub
  import rev_addsub_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [WIDTH-1:0]               a_i,
  input  logic [WIDTH-1:0]               b_i,
  input  logic                           sub_i,
  output logic [WIDTH-1:0]               res_o,
  output logic                           cb_o,
  output logic [2+3*(WIDTH-1)-1:0]       garb_o
);
  localparam int unsigned GW = garb_width(WIDTH);

  // Named internal events for the checker
  logic [WIDTH-1:0] res_w;
  logic [WIDTH-1:0] cb_w;
  logic [GW-1:0]    garb_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_half
      rev_half_cell u_cell (
        .a_i(a_i[0]), .b_i(b_i[0]), .mode_i(sub_i),
        .d_o(res_w[0]), .cout_o(cb_w[0]), .garb_o(garb_w[HALF_GARB-1:0])
      );
    end else begin : g_full
      localparam int unsigned BASE = HALF_GARB + FULL_GARB * (i - 1);
      rev_full_cell u_cell (
        .a_i(a_i[i]), .b_i(b_i[i]), .mode_i(sub_i), .cin_i(cb_w[i-1]),
        .d_o(res_w[i]), .cout_o(cb_w[i]), .garb_o(garb_w[BASE+FULL_GARB-1:BASE])
      );
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_o  <= '0;
        cb_o   <= 1'b0;
        garb_o <= '0;
      end else begin
        res_o  <= res_w;
        cb_o   <= cb_w[WIDTH-1];
        garb_o <= garb_w;
      end
    end
  end else begin : g_comb
    assign res_o  = res_w;
    assign cb_o   = cb_w[WIDTH-1];
    assign garb_o = garb_w;
  end

endmodule

// File: rtl/rev_addsub_checker.sv
module rev_addsub_checker #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [WIDTH-1:0]         a_i,
  input logic [WIDTH-1:0]         b_i,
  input logic                     sub_i,
  input logic [WIDTH-1:0]         res_o,
  input logic                     cb_o,
  input logic [2+3*(WIDTH-1)-1:0] garb_o,
  input logic [WIDTH-1:0]         res_w,
  input logic [WIDTH-1:0]         cb_w
);
  // R6: result bits see only operands and the incoming chain
  assert_chain_xor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_w == (a_i ^ b_i ^ {cb_w[WIDTH-2:0], 1'b0}));

  assert_bit0_mode_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_w[0] == (a_i[0] ^ b_i[0]));

  if (REG_OUT) begin : g_timed
    // R4: registered sum one edge later
    assert_add_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sub_i |=> {cb_o, res_o} == ($past({1'b0, a_i}) + $past({1'b0, b_i})));

    // R5: registered difference and borrow
    assert_sub_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |=> (res_o == $past(a_i - b_i)) && (cb_o == $past(a_i < b_i)));

    // R7 / R8: mode line in garbage tracks the applied mode one edge later
    assert_garb_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> garb_o[1] == $past(sub_i));

    // R9: outputs cleared during reset
    assert_reset_clear_R9: assert property (@(posedge clk)
      !rst_n |-> (res_o == '0) && !cb_o && (garb_o == '0));
  end
endmodule

bind rev_addsub rev_addsub_checker #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
  .res_o(res_o), .cb_o(cb_o), .garb_o(garb_o), .res_w(res_w), .cb_w(cb_w)
);

// File: tb/rev_addsub_bench.sv
module rev_addsub_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  a_r = '0, b_r = '0;
  logic        s_r = 1'b0;
  logic [7:0]  res;
  logic        cb;
  logic [22:0] garb;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rev_addsub u_rev_addsub (
    .clk(clk), .rst_n(rst_n), .a_i(a_r), .b_i(b_r), .sub_i(s_r),
    .res_o(res), .cb_o(cb), .garb_o(garb)
  );

  // Stand-alone primitives for the exhaustive sweep
  logic fx, fy, fp, fq;
  logic px, py, pz, pp, pq, pr;
  rev_feynman u_cnot (.a_i(fx), .b_i(fy), .p_o(fp), .q_o(fq));
  rev_peres   u_per  (.a_i(px), .b_i(py), .c_i(pz), .p_o(pp), .q_o(pq), .r_o(pr));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] exp_garb(input logic [7:0] a, input logic [7:0] b, input logic m);
    logic [22:0] g;
    g[0] = a[0] ^ m;
    g[1] = m;
    for (int i = 1; i < 8; i++) begin
      g[2 + 3*(i-1)]     = a[i] ^ m;
      g[2 + 3*(i-1) + 1] = (a[i] ^ m) ^ b[i];
      g[2 + 3*(i-1) + 2] = m;
    end
    return g;
  endfunction

  // Apply one vector at a falling edge, check one full cycle later
  task automatic run_vec(input logic [7:0] a, input logic [7:0] b, input logic m);
    int full;
    @(negedge clk);
    a_r = a; b_r = b; s_r = m;
    @(negedge clk);
    if (!m) begin
      full = int'(a) + int'(b);
      chk("R4 sum", {55'd0, cb, res}, 64'(full));
    end else begin
      full = int'(a) - int'(b);
      chk("R5 difference", 64'(res), 64'(full & 255));
      chk("R5 borrow", 64'(cb), 64'(a < b));
    end
    chk("R6 bit0", 64'(res[0]), 64'(a[0] != b[0]));
    chk("R7 garbage", 64'(garb), 64'(exp_garb(a, b, m)));
  endtask

  task automatic t_reset;
    @(negedge clk);
    a_r = 8'hA5; b_r = 8'h3C; s_r = 1'b1;
    @(negedge clk);
    chk("R9 res", 64'(res), 64'd0);
    chk("R9 cb", 64'(cb), 64'd0);
    chk("R9 garb", 64'(garb), 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_primitives;
    logic [3:0] seen2 = '0;
    logic [7:0] seen3 = '0;
    for (int v = 0; v < 4; v++) begin
      fx = v[1]; fy = v[0];
      #1;
      chk("R1 cnot", {62'd0, fp, fq}, {62'd0, v[1], v[1] != v[0]});
      seen2[{fp, fq}] = 1'b1;
    end
    chk("R3 cnot one-to-one", 64'(seen2), 64'hF);
    for (int v = 0; v < 8; v++) begin
      px = v[2]; py = v[1]; pz = v[0];
      #1;
      chk("R2 peres", {61'd0, pp, pq, pr},
          {61'd0, v[2], v[2] != v[1], (v[2] && v[1]) != v[0]});
      seen3[{pp, pq, pr}] = 1'b1;
    end
    chk("R3 peres one-to-one", 64'(seen3), 64'hFF);
  endtask

  task automatic t_add_directed;
    run_vec(8'h00, 8'h00, 1'b0);
    run_vec(8'hFF, 8'h01, 1'b0);  // R4 full ripple carry
    run_vec(8'hFF, 8'hFF, 1'b0);
    run_vec(8'h55, 8'hAA, 1'b0);  // propagate everywhere, no carry
    run_vec(8'h80, 8'h80, 1'b0);
  endtask

  task automatic t_sub_directed;
    run_vec(8'h00, 8'h01, 1'b1);  // R5 full ripple borrow
    run_vec(8'h01, 8'h01, 1'b1);
    run_vec(8'hFF, 8'h00, 1'b1);
    run_vec(8'h00, 8'hFF, 1'b1);
    run_vec(8'h7F, 8'h80, 1'b1);
    run_vec(8'h80, 8'h7F, 1'b1);
  endtask

  task automatic t_random;
    for (int n = 0; n < 200; n++)
      run_vec(8'($urandom), 8'($urandom), 1'($urandom));
  endtask

  task automatic t_latency;
    run_vec(8'h10, 8'h20, 1'b0);        // known prior state: 0x30
    @(negedge clk);
    a_r = 8'h05; b_r = 8'h09; s_r = 1'b1;
    @(posedge clk);
    #1;  // just after the capture edge: new value only now
    chk("R8 after edge", {55'd0, cb, res}, {55'd0, 1'b1, 8'hFC});
    @(negedge clk);
    a_r = 8'h40; b_r = 8'h01; s_r = 1'b0;
    #1;  // before the next edge: previous result still held
    chk("R8 held before edge", {55'd0, cb, res}, {55'd0, 1'b1, 8'hFC});
    chk("R8 garbage held", 64'(garb), 64'(exp_garb(8'h05, 8'h09, 1'b1)));
    @(negedge clk);
    chk("R8 next result", {55'd0, cb, res}, {55'd0, 1'b0, 8'h41});
  endtask

  initial begin
    t_primitives();
    t_reset();
    t_add_directed();
    t_sub_directed();
    t_latency();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule